// File: doc/BRIEF.md
# First-Order Recursive Filter with Selectable Requantization

This block is a single-pole recursive filter. Each accepted sample updates a fixed-point state by the rule y_new = Q(a * y_old) + x, where `a` is a signed coefficient and Q() cuts the wide product back to the width of the state. The cut is always a truncation, never a rounding. A mode input chooses which way the truncation falls. In one mode the product is truncated toward zero, which is the behaviour of a magnitude-and-sign datapath. In the other mode it is truncated toward minus infinity, which is what a two's complement datapath does when it drops the low bits.

The block is used to study small-signal behaviour with no input. With the toward-zero rule, the region that truncates to zero is symmetric about zero, so a decaying filter with |a| < 1 always settles at exactly zero. With the floor rule, that region covers only small positive values. A small negative state can therefore lock onto a nonzero value and never decay. A load port seeds the state directly, so that a decay run can start from any value.

The state is held in two's complement in both modes. With the defaults, the state is 16 bits wide with 12 fraction bits and the coefficient is 16 bits with 14 fraction bits. The sum wraps on overflow and is not saturated.

Top module: `fo_quant_filter`

## Requirements
- R1: While reset is applied, and until the first seed or sample after reset is released, `y_out` reads zero.
- R2: When `seed_en` is high at a clock edge, `y_out` equals `seed_val` after that edge, even if `smp_vld` is high in the same cycle.
- R3: In a cycle where both `seed_en` and `smp_vld` are low, `y_out` does not change, whatever values `smp_in`, `coef` and `mode` carry.
- R4: When `smp_vld` is high and `seed_en` is low, the state becomes Q(coef * y_out) + smp_in. The 32-bit product (26 fraction bits) is reduced by removing its 14 low bits, and the sum wraps modulo 2^16 with no saturation.
- R5: With `mode` = 0, Q truncates toward minus infinity. A negative product with nonzero removed bits goes to the next more negative state code.
- R6: With `mode` = 1, Q truncates toward zero. Any product whose magnitude is below one state LSB becomes exactly 0, whatever its sign.
- R7: With `mode` = 1, `smp_in` = 0 and |coef| < 1.0, the state magnitude never grows. From a seed of -10 LSB with coef = 16220 (about 0.99), the state reaches 0 within 20 samples and then stays at 0.
- R8: With `mode` = 0, `smp_in` = 0 and coef = 16220, a seed of -10 LSB is a fixed point and the state stays nonzero indefinitely. A seed of +10 LSB decays to 0 under the same conditions.
- R9: For products below one LSB: y = +1 with coef = 8192 (0.5) gives 0 in both modes. y = -1 with coef = 8192 gives -1 with `mode` = 0 and 0 with `mode` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Takes effect asynchronously and is released in step with `clk` |
| smp_vld | input | 1 | Accept `smp_in` and update the state at this edge |
| smp_in | input | STATE_W | Input sample, signed, same format as the state |
| coef | input | COEF_W | Feedback coefficient, signed, COEF_FRAC fraction bits |
| mode | input | 1 | 0: truncate toward minus infinity; 1: truncate toward zero |
| seed_en | input | 1 | Load `seed_val` into the state; has priority over `smp_vld` |
| seed_val | input | STATE_W | Value to load into the state |
| y_out | output | STATE_W | Current filter state, signed |

## Verification
The bench builds the filter with its default parameters: a 16-bit state and a 16-bit coefficient with 14 fraction bits. With this sizing, a state only a few LSB away from zero meets a coefficient of about 0.99 within a handful of samples, so a persistent floor-mode fixed point and a complete toward-zero decay both show up in under 30 updates. Seeds near the top of the ±8.0 range make the wrapping sum easy to reach, and a coefficient of 0.5 puts a product exactly one half-LSB away from zero on either side.

// File: rtl/fq_pkg.sv
package fq_pkg;
  // Requantization rule applied to the feedback product
  typedef enum logic {
    QM_FLOOR       = 1'b0,  // drop low bits: toward minus infinity
    QM_TOWARD_ZERO = 1'b1   // magnitude truncation
  } qmode_e;
endpackage

// File: rtl/fq_rst_sync.sv
// Reset conditioner: asserts at once, releases after two clock edges.
module fq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fq_coef_mult.sv
// Full-precision signed product of state and coefficient.
module fq_coef_mult #(
  parameter int A_W = 16,
  parameter int B_W = 16,
  localparam int P_W = A_W + B_W
) (
  input  logic signed [A_W-1:0] a_in,
  input  logic signed [B_W-1:0] b_in,
  output logic signed [P_W-1:0] p_out
);
  logic signed [P_W-1:0] a_ext;
  logic signed [P_W-1:0] b_ext;

  always_comb begin
    a_ext = P_W'(a_in);
    b_ext = P_W'(b_in);
    p_out = a_ext * b_ext;
  end
endmodule

// File: rtl/fq_requant.sv
// Removes DROP_W low bits of a signed product and returns OUT_W bits.
module fq_requant
  import fq_pkg::*;
#(
  parameter int IN_W   = 32,
  parameter int DROP_W = 14,
  parameter int OUT_W  = 16
) (
  input  qmode_e                   rule,
  input  logic signed [IN_W-1:0]   prod,
  output logic signed [OUT_W-1:0]  q_out
);
  logic signed [IN_W-1:0] shifted;
  logic                   lost_bits;
  logic                   bump;

  generate
    if (DROP_W > 0) begin : g_drop
      always_comb begin
        shifted   = prod >>> DROP_W;
        lost_bits = |prod[DROP_W-1:0];
      end
    end else begin : g_pass
      always_comb begin
        shifted   = prod;
        lost_bits = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    // The shift already floors; toward-zero lifts negatives that lost bits
    bump  = (rule == QM_TOWARD_ZERO) && prod[IN_W-1] && lost_bits;
    q_out = shifted[OUT_W-1:0] + {{(OUT_W-1){1'b0}}, bump};
  end
endmodule

// File: rtl/fo_quant_filter.sv
module fo_quant_filter
  import fq_pkg::*;
#(
  parameter int STATE_W   = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smp_vld,
  input  logic signed [STATE_W-1:0] smp_in,
  input  logic signed [COEF_W-1:0]  coef,
  input  logic                      mode,
  input  logic                      seed_en,
  input  logic signed [STATE_W-1:0] seed_val,
  output logic signed [STATE_W-1:0] y_out
);
  localparam int PROD_W = STATE_W + COEF_W;

  logic                      rst_sync_n;
  logic signed [STATE_W-1:0] state_q;
  logic signed [STATE_W-1:0] state_d;
  logic                      state_en;
  logic signed [PROD_W-1:0]  prod;
  logic signed [STATE_W-1:0] fb_q;

  fq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fq_coef_mult #(.A_W(STATE_W), .B_W(COEF_W)) u_mul (
    .a_in  (state_q),
    .b_in  (coef),
    .p_out (prod)
  );

  fq_requant #(.IN_W(PROD_W), .DROP_W(COEF_FRAC), .OUT_W(STATE_W)) u_rq (
    .rule  (qmode_e'(mode)),
    .prod  (prod),
    .q_out (fb_q)
  );

  // Next state: a seed load wins over a sample
  always_comb begin
    state_en = seed_en | smp_vld;
    state_d  = state_q;
    if (seed_en)      state_d = seed_val;
    else if (smp_vld) state_d = fb_q + smp_in;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   state_q <= '0;
    else if (state_en) state_q <= state_d;
  end

  assign y_out = state_q;
endmodule

// File: rtl/fq_checker.sv
module fq_checker #(
  parameter int STATE_W   = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14
) (
  input logic                      clk,
  input logic                      rst_ok,
  input logic                      smp_vld,
  input logic signed [STATE_W-1:0] smp_in,
  input logic signed [COEF_W-1:0]  coef,
  input logic                      mode,
  input logic                      seed_en,
  input logic signed [STATE_W-1:0] seed_val,
  input logic signed [STATE_W-1:0] y_out
);
  localparam int ONE = 1 << COEF_FRAC;

  function automatic int mag(input int v);
    return (v < 0) ? -v : v;
  endfunction

  logic coef_below_one;
  logic coef_unit_pos;
  logic zero_step;

  always_comb begin
    coef_below_one = (int'(coef) > -ONE) && (int'(coef) < ONE);
    coef_unit_pos  = (int'(coef) >= 0) && (int'(coef) < ONE);
    zero_step      = smp_vld && !seed_en && (smp_in == '0);
  end

  p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    seed_en |=> (y_out == $past(seed_val)));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (!seed_en && !smp_vld) |=> $stable(y_out));

  p_floor_bounds_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (zero_step && !mode && coef_unit_pos && (int'(y_out) < 0))
      |=> ((int'(y_out) <= 0) && (int'(y_out) >= int'($past(y_out)))));

  p_tz_no_grow_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (zero_step && mode && coef_below_one)
      |=> (mag(int'(y_out)) <= mag(int'($past(y_out)))));

  p_tz_zero_stays_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (zero_step && mode && (y_out == '0)) |=> (y_out == '0));
endmodule

bind fo_quant_filter fq_checker #(
  .STATE_W   (STATE_W),
  .COEF_W    (COEF_W),
  .COEF_FRAC (COEF_FRAC)
) u_chk (
  .clk      (clk),
  .rst_ok   (rst_sync_n),
  .smp_vld  (smp_vld),
  .smp_in   (smp_in),
  .coef     (coef),
  .mode     (mode),
  .seed_en  (seed_en),
  .seed_val (seed_val),
  .y_out    (y_out)
);

// File: tb/sim_fo_quant_filter.sv
`timescale 1ns/1ps
module sim_fo_quant_filter;
  localparam int SCALE = 16384;      // 2^COEF_FRAC
  localparam int A99   = 16220;      // ~0.99
  localparam int AHALF = 8192;       // 0.5

  logic               clk = 1'b0;
  logic               rst_n;
  logic               smp_vld;
  logic signed [15:0] smp_in;
  logic signed [15:0] coef;
  logic               mode;
  logic               seed_en;
  logic signed [15:0] seed_val;
  logic signed [15:0] y_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fo_quant_filter u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
    .coef(coef), .mode(mode), .seed_en(seed_en), .seed_val(seed_val),
    .y_out(y_out)
  );

  function automatic int wrap16(input longint v);
    logic [15:0] t;
    t = v[15:0];
    return int'($signed(t));
  endfunction

  // Expected update computed from R4..R6
  function automatic int model(input int y, input int a, input int x, input bit m);
    longint p;
    longint q;
    p = longint'(y) * longint'(a);
    if (m)           q = p / SCALE;                       // toward zero
    else if (p >= 0) q = p / SCALE;
    else             q = -((-p + SCALE - 1) / SCALE);     // floor
    return wrap16(q + longint'(x));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit s, input int x, input int sv,
                      input int a, input bit m);
    @(negedge clk);
    smp_vld = v; seed_en = s; smp_in = 16'(x); seed_val = 16'(sv);
    coef = 16'(a); mode = m;
    @(posedge clk); #1;
    smp_vld = 1'b0; seed_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; smp_vld = 1'b0; seed_en = 1'b0; smp_in = '0;
    seed_val = '0; coef = '0; mode = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk(y_out == 0, "R1 during reset", int'(y_out), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(y_out == 0, "R1 after release", int'(y_out), 0);
  endtask

  task automatic t_seed();
    step(1'b0, 1'b1, 0, 1234, 0, 1'b0);
    chk(y_out == 1234, "R2 seed load", int'(y_out), 1234);
    step(1'b1, 1'b1, 500, -777, A99, 1'b0);
    chk(y_out == -777, "R2 seed beats sample", int'(y_out), -777);
  endtask

  task automatic t_hold();
    step(1'b0, 1'b1, 0, 4321, 0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, 3000 + i, -5, 9000 - i, i[0]);
      chk(y_out == 4321, "R3 idle hold", int'(y_out), 4321);
    end
  endtask

  task automatic t_update();
    int exp;
    int y0 [4] = '{3000, -3000, 28672, -20001};
    int aa [4] = '{12345, -9876, 16383, 15000};
    int xx [4] = '{-100, 250, 8192, -20000};
    for (int i = 0; i < 4; i++) begin
      for (int m = 0; m < 2; m++) begin
        step(1'b0, 1'b1, 0, y0[i], 0, 1'b0);
        step(1'b1, 1'b0, xx[i], 0, aa[i], m[0]);
        exp = model(y0[i], aa[i], xx[i], m[0]);
        chk(int'(y_out) == exp, m ? "R4 R6 update" : "R4 R5 update", int'(y_out), exp);
      end
    end
    // Chained updates in floor mode, input nonzero
    step(1'b0, 1'b1, 0, -4097, 0, 1'b0);
    exp = -4097;
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b0, 77, 0, -11111, 1'b0);
      exp = model(exp, -11111, 77, 1'b0);
      chk(int'(y_out) == exp, "R5 chained", int'(y_out), exp);
    end
  endtask

  task automatic t_small();
    step(1'b0, 1'b1, 0, 1, 0, 1'b0);
    step(1'b1, 1'b0, 0, 0, AHALF, 1'b0);
    chk(y_out == 0, "R9 +half floor", int'(y_out), 0);
    step(1'b0, 1'b1, 0, 1, 0, 1'b0);
    step(1'b1, 1'b0, 0, 0, AHALF, 1'b1);
    chk(y_out == 0, "R9 +half tz", int'(y_out), 0);
    step(1'b0, 1'b1, 0, -1, 0, 1'b0);
    step(1'b1, 1'b0, 0, 0, AHALF, 1'b0);
    chk(y_out == -1, "R9 R5 -half floor", int'(y_out), -1);
    step(1'b0, 1'b1, 0, -1, 0, 1'b0);
    step(1'b1, 1'b0, 0, 0, AHALF, 1'b1);
    chk(y_out == 0, "R9 R6 -half tz", int'(y_out), 0);
  endtask

  task automatic t_decay_tz();
    int hit = -1;
    int prev = -10;
    bit mono = 1'b1;
    step(1'b0, 1'b1, 0, -10, 0, 1'b1);
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 1'b0, 0, 0, A99, 1'b1);
      if ((int'(y_out) < prev) || (int'(y_out) > 0)) mono = 1'b0;
      prev = int'(y_out);
      if (hit < 0 && y_out == 0) hit = i + 1;
    end
    chk(mono, "R7 magnitude never grows", prev, 0);
    chk(hit > 0 && hit <= 20, "R7 reaches zero", hit, 10);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 0, 0, A99, 1'b1);
    chk(y_out == 0, "R7 stays zero", int'(y_out), 0);
  endtask

  task automatic t_limit_floor();
    bit held = 1'b1;
    step(1'b0, 1'b1, 0, -10, 0, 1'b0);
    for (int i = 0; i < 30; i++) begin
      step(1'b1, 1'b0, 0, 0, A99, 1'b0);
      if (y_out != -10) held = 1'b0;
    end
    chk(held, "R8 negative fixed point", int'(y_out), -10);
    step(1'b0, 1'b1, 0, 10, 0, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 0, 0, A99, 1'b0);
    chk(y_out == 0, "R8 positive seed decays", int'(y_out), 0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    t_reset();
    t_seed();
    t_hold();
    t_update();
    t_small();
    t_decay_tz();
    t_limit_floor();
    report();
  end
endmodule